// File: doc/BRIEF.md
# Configurable GPIO Pad Controller

This block is the digital control for a single general-purpose I/O channel of a power-management peripheral. Software configures it through a byte-wide register window: one register for direction, output value and output-source selection, and others for supply rail, pull bias, drive strength, output buffer style and a master enable. From this configuration the block drives the pad's output level, output enable, input enable and bias controls, and it returns the live pad level through a status register.

A simple synchronous port stands in for the serial register bus. Writes take effect on the clock edge that samples them. Read data is registered and appears one cycle after the read strobe. The channel variant is fixed by a parameter holding the subtype code. The subtype sets the number of supply rails and whether the output buffer style can be changed.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00 (input only, function 0, output low), bias reads 0x05 (no pull), drive register reads 0x00 (strength none, push-pull), rail reads 0x00 and enable reads 0x80 (master enable set). After reset pad_oe_o is 0 and in_en_o is 1.
- R2: Offset 0x04 reads 0x10 and offset 0x05 reads the SUBTYPE parameter. Writes to these offsets are ignored. Any offset not listed in R1–R12 reads 0x00. Read data appears on rd_data_o one cycle after rd_en_i.
- R3: The mode register at 0x40 holds the output value in bit 0, the function select in bits 3:1 and the direction code in bits 6:4. It reads back as written, with bit 7 reading 0.
- R4: Direction code 0 enables the input only. Code 1 enables the output only. Code 2 enables both. Codes 3 to 7 enable neither, so pad_oe_o and in_en_o are both 0.
- R5: Function code 0 drives pad_out_o from the mode register's bit 0. Function code k in 1..7 drives pad_out_o from alt_src_i[k-1].
- R6: Buffer code (bits 5:4 of 0x45) 0 is push-pull. Code 1 asserts pad_oe_o only while the output level is 0. Code 2 asserts pad_oe_o only while the output level is 1. Code 3 behaves as push-pull.
- R7: When bit 7 of 0x46 is 0, pad_oe_o, in_en_o, pull_up_o, pull_dn_o and drive_str_o are all 0, whatever the other settings.
- R8: Bits 2:0 of 0x41 select the rail. Subtypes 0x01 and 0x05 have 4 rails; subtypes 0x09 and 0x0D have 8. A written value at or above the rail count is stored as the rail count minus one. rail_sel_o follows the stored value.
- R9: Bias code (0x42 bits 2:0) 0–3 asserts pull_up_o, with pull_up_sel_o equal to the code. Code 4 asserts pull_dn_o. Codes 5–7 assert neither.
- R10: On subtypes 0x05 and 0x0D the buffer field always reads 0, and the pad behaves as push-pull.
- R11: Bit 0 of the status register at 0x10 returns pad_in_i while in_en_o is 1; otherwise the status register reads 0x00.
- R12: drive_str_o equals bits 1:0 of 0x45 (0 none, 1 high, 2 medium, 3 low) while the master enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register offset within the channel window |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, one cycle after rd_en_i |
| alt_src_i | input | NUM_FUNC-1 | Alternate output sources for functions 1..7 |
| pad_in_i | input | 1 | Live pad level |
| pad_out_o | output | 1 | Level presented to the pad driver |
| pad_oe_o | output | 1 | Pad driver enable |
| in_en_o | output | 1 | Pad input buffer enable |
| pull_up_o | output | 1 | Pull-up enable |
| pull_dn_o | output | 1 | Pull-down enable |
| pull_up_sel_o | output | 2 | Pull-up variant |
| drive_str_o | output | 2 | Drive strength |
| rail_sel_o | output | 3 | Supply rail select |

## Verification
All pad controls are combinational decodes of the stored configuration, so a wrong stored field shows up at the pad pins in the cycle after the write that set it. Examples are a direction or buffer code decoded wrongly, a rail left unclamped, or a buffer field kept on a channel that has no configurable buffer. The bench samples the pad pins right after each write and reads every register back, so a corrupted field is caught at once. A status path that ignores the input enable would return a nonzero level during an output-only read. That error shows one cycle after the read strobe.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam logic [7:0] OFS_TYPE    = 8'h04;
  localparam logic [7:0] OFS_SUBTYPE = 8'h05;
  localparam logic [7:0] OFS_STATUS  = 8'h10;
  localparam logic [7:0] OFS_MODE    = 8'h40;
  localparam logic [7:0] OFS_RAIL    = 8'h41;
  localparam logic [7:0] OFS_BIAS    = 8'h42;
  localparam logic [7:0] OFS_DRIVE   = 8'h45;
  localparam logic [7:0] OFS_ENABLE  = 8'h46;
  localparam logic [7:0] TYPE_ID     = 8'h10;
  localparam logic [2:0] BIAS_NONE   = 3'd5;
  localparam logic [2:0] BIAS_DOWN   = 3'd4;

  localparam logic [1:0] BUF_PUSH_PULL   = 2'd0;
  localparam logic [1:0] BUF_SINK_ONLY   = 2'd1;
  localparam logic [1:0] BUF_SOURCE_ONLY = 2'd2;

  typedef struct packed {
    logic [2:0] dir;
    logic [2:0] func;
    logic       out_val;
    logic [2:0] rail;
    logic [2:0] bias;
    logic [1:0] buf_kind;
    logic [1:0] strength;
    logic       master_en;
  } pad_cfg_t;

  function automatic int unsigned rail_count(logic [7:0] st);
    return (st == 8'h09 || st == 8'h0D) ? 8 : 4;
  endfunction

  function automatic logic has_buffer(logic [7:0] st);
    return (st == 8'h01 || st == 8'h09);
  endfunction
endpackage

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_pad_pkg::*;
#(
  parameter logic [7:0] SUBTYPE = 8'h09,
  parameter int         ADDR_W  = 8,
  parameter int         DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              status_i,
  output pad_cfg_t          cfg_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned RAILS   = rail_count(SUBTYPE);
  localparam logic [2:0]  RAIL_HI = 3'(RAILS - 1);
  localparam logic        HAS_BUF = has_buffer(SUBTYPE);

  pad_cfg_t    cfg_q;
  logic [7:0]  rd_mux;
  logic [1:0]  buf_wr;

  generate
    if (HAS_BUF) begin : g_buf
      assign buf_wr = wr_data_i[5:4];
    end else begin : g_nobuf
      assign buf_wr = BUF_PUSH_PULL;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q           <= '0;
      cfg_q.bias      <= BIAS_NONE;
      cfg_q.master_en <= 1'b1;
    end else if (wr_en_i) begin
      case (8'(addr_i))
        OFS_MODE: begin
          cfg_q.out_val <= wr_data_i[0];
          cfg_q.func    <= wr_data_i[3:1];
          cfg_q.dir     <= wr_data_i[6:4];
        end
        OFS_RAIL:
          cfg_q.rail <= ({1'b0, wr_data_i[2:0]} >= 4'(RAILS)) ? RAIL_HI : wr_data_i[2:0];
        OFS_BIAS:   cfg_q.bias <= wr_data_i[2:0];
        OFS_DRIVE: begin
          cfg_q.strength <= wr_data_i[1:0];
          cfg_q.buf_kind <= buf_wr;
        end
        OFS_ENABLE: cfg_q.master_en <= wr_data_i[7];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (8'(addr_i))
      OFS_TYPE:    rd_mux = TYPE_ID;
      OFS_SUBTYPE: rd_mux = SUBTYPE;
      OFS_STATUS:  rd_mux = {7'b0, status_i};
      OFS_MODE:    rd_mux = {1'b0, cfg_q.dir, cfg_q.func, cfg_q.out_val};
      OFS_RAIL:    rd_mux = {5'b0, cfg_q.rail};
      OFS_BIAS:    rd_mux = {5'b0, cfg_q.bias};
      OFS_DRIVE:   rd_mux = {2'b0, cfg_q.buf_kind, 2'b0, cfg_q.strength};
      OFS_ENABLE:  rd_mux = {cfg_q.master_en, 7'b0};
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= DATA_W'(rd_mux);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_pad_pkg::*;
#(
  parameter int NUM_FUNC = 8,
  localparam int NUM_ALT = NUM_FUNC - 1
) (
  input  pad_cfg_t           cfg_i,
  input  logic [NUM_ALT-1:0] alt_src_i,
  output logic               pad_out_o,
  output logic               pad_oe_o,
  output logic               in_en_o,
  output logic               pull_up_o,
  output logic               pull_dn_o,
  output logic [1:0]         pull_up_sel_o,
  output logic [1:0]         drive_str_o,
  output logic [2:0]         rail_sel_o
);
  logic [NUM_FUNC-1:0] src_vec;
  logic                level;
  logic                out_path, in_path, buf_ok;

  assign src_vec = {alt_src_i, cfg_i.out_val};
  assign level   = src_vec[cfg_i.func];

  assign out_path = (cfg_i.dir == 3'd1) || (cfg_i.dir == 3'd2);
  assign in_path  = (cfg_i.dir == 3'd0) || (cfg_i.dir == 3'd2);

  always_comb begin
    case (cfg_i.buf_kind)
      BUF_SINK_ONLY:   buf_ok = ~level;
      BUF_SOURCE_ONLY: buf_ok = level;
      default:         buf_ok = 1'b1;
    endcase
  end

  assign pad_out_o     = level;
  assign pad_oe_o      = cfg_i.master_en & out_path & buf_ok;
  assign in_en_o       = cfg_i.master_en & in_path;
  assign pull_up_o     = cfg_i.master_en & ~cfg_i.bias[2];
  assign pull_dn_o     = cfg_i.master_en & (cfg_i.bias == BIAS_DOWN);
  assign pull_up_sel_o = cfg_i.bias[1:0];
  assign drive_str_o   = cfg_i.master_en ? cfg_i.strength : 2'd0;
  assign rail_sel_o    = cfg_i.rail;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter logic [7:0] SUBTYPE  = 8'h09,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter int         NUM_FUNC = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_FUNC-2:0] alt_src_i,
  input  logic                pad_in_i,
  output logic                pad_out_o,
  output logic                pad_oe_o,
  output logic                in_en_o,
  output logic                pull_up_o,
  output logic                pull_dn_o,
  output logic [1:0]          pull_up_sel_o,
  output logic [1:0]          drive_str_o,
  output logic [2:0]          rail_sel_o
);
  pad_cfg_t   cfg;
  logic       status;
  logic       master_en;
  logic [2:0] dir_code;
  logic [1:0] buf_code;

  assign status    = in_en_o & pad_in_i;
  assign master_en = cfg.master_en;
  assign dir_code  = cfg.dir;
  assign buf_code  = cfg.buf_kind;

  gpio_pad_regs #(
    .SUBTYPE(SUBTYPE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .status_i(status),
    .cfg_o(cfg), .rd_data_o(rd_data_o)
  );

  gpio_pad_drive #(.NUM_FUNC(NUM_FUNC)) u_drive (
    .cfg_i(cfg), .alt_src_i(alt_src_i), .pad_out_o(pad_out_o),
    .pad_oe_o(pad_oe_o), .in_en_o(in_en_o), .pull_up_o(pull_up_o),
    .pull_dn_o(pull_dn_o), .pull_up_sel_o(pull_up_sel_o),
    .drive_str_o(drive_str_o), .rail_sel_o(rail_sel_o)
  );
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter logic [7:0] SUBTYPE = 8'h09,
  parameter int         ADDR_W  = 8,
  parameter int         DATA_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              pad_out_o,
  input logic              pad_oe_o,
  input logic              in_en_o,
  input logic              pull_up_o,
  input logic              pull_dn_o,
  input logic [1:0]        drive_str_o,
  input logic [2:0]        rail_sel_o,
  input logic              master_en,
  input logic [2:0]        dir_code,
  input logic [1:0]        buf_code
);
  localparam int unsigned RAILS = gpio_pad_pkg::rail_count(SUBTYPE);

  // R7
  hiz_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en |-> (!pad_oe_o && !in_en_o && !pull_up_o && !pull_dn_o && drive_str_o == 2'd0));

  // R4
  bad_dir_no_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_code > 3'd2) |-> (!pad_oe_o && !in_en_o));

  // R6
  sink_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o && buf_code == 2'd1) |-> !pad_out_o);

  // R6
  source_high_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o && buf_code == 2'd2) |-> pad_out_o);

  // R8
  rail_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, rail_sel_o} < 4'(RAILS));

  // R9
  pull_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pull_up_o && pull_dn_o));

  // R2
  type_id_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && 8'(addr_i) == 8'h04) |=> (8'(rd_data_o) == 8'h10));
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(
  .SUBTYPE(SUBTYPE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .rd_data_o(rd_data_o), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
  .in_en_o(in_en_o), .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o),
  .drive_str_o(drive_str_o), .rail_sel_o(rail_sel_o),
  .master_en(master_en), .dir_code(dir_code), .buf_code(buf_code)
);

// File: tb/gpio_pad_ctrl_test.sv
module gpio_pad_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [6:0] alt = '0;
  logic       pad_in = 1'b0;
  logic [7:0] rdata, nb_rdata;
  logic       pad_out, pad_oe, in_en, pu, pd;
  logic [1:0] pu_sel, dstr;
  logic [2:0] rail;
  logic       nb_out, nb_oe, nb_in_en, nb_pu, nb_pd;
  logic [1:0] nb_pu_sel, nb_dstr;
  logic [2:0] nb_rail;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_pad_ctrl #(.SUBTYPE(8'h09)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .alt_src_i(alt), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .in_en_o(in_en), .pull_up_o(pu),
    .pull_dn_o(pd), .pull_up_sel_o(pu_sel), .drive_str_o(dstr), .rail_sel_o(rail));

  gpio_pad_ctrl #(.SUBTYPE(8'h05)) uut_nb (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(nb_rdata), .alt_src_i(alt), .pad_in_i(pad_in),
    .pad_out_o(nb_out), .pad_oe_o(nb_oe), .in_en_o(nb_in_en), .pull_up_o(nb_pu),
    .pull_dn_o(nb_pd), .pull_up_sel_o(nb_pu_sel), .drive_str_o(nb_dstr), .rail_sel_o(nb_rail));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d, output logic [7:0] dn);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk); rd_en = 1'b0; d = rdata; dn = nb_rdata;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d, dn;
    rd(a, d, dn);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    rchk("R1 mode", 8'h40, 8'h00);
    rchk("R1 rail", 8'h41, 8'h00);
    rchk("R1 bias", 8'h42, 8'h05);
    rchk("R1 drive", 8'h45, 8'h00);
    rchk("R1 enable", 8'h46, 8'h80);
    check("R1 pad_oe", {7'b0, pad_oe}, 8'h00);
    check("R1 in_en", {7'b0, in_en}, 8'h01);
  endtask

  task automatic t_ident;
    logic [7:0] d, dn;
    rchk("R2 type", 8'h04, 8'h10);
    rchk("R2 subtype", 8'h05, 8'h09);
    wr(8'h04, 8'hAA);
    rchk("R2 type write ignored", 8'h04, 8'h10);
    rchk("R2 unmapped 0x43", 8'h43, 8'h00);
    rchk("R2 unmapped 0x07", 8'h07, 8'h00);
    rd(8'h05, d, dn);
    check("R2 subtype variant", dn, 8'h05);
  endtask

  task automatic t_dir;
    wr(8'h40, 8'h11);
    rchk("R3 mode readback", 8'h40, 8'h11);
    check("R4 out-only oe", {6'b0, pad_oe, in_en}, 8'h02);
    check("R4 out-only level", {7'b0, pad_out}, 8'h01);
    wr(8'h40, 8'h20);
    check("R4 bidir oe/in", {6'b0, pad_oe, in_en}, 8'h03);
    wr(8'h40, 8'h30);
    check("R4 invalid dir", {6'b0, pad_oe, in_en}, 8'h00);
    rchk("R3 invalid dir readback", 8'h40, 8'h30);
    wr(8'h40, 8'hFF);
    rchk("R3 bit7 reads 0", 8'h40, 8'h7F);
    check("R4 dir7 no path", {6'b0, pad_oe, in_en}, 8'h00);
  endtask

  task automatic t_func;
    alt = 7'b0000100;
    wr(8'h40, 8'h16);
    check("R5 func3 alt high", {7'b0, pad_out}, 8'h01);
    @(negedge clk); alt = 7'b1111011;
    #1 check("R5 func3 alt low", {7'b0, pad_out}, 8'h00);
    @(negedge clk); alt = 7'b1000000;
    wr(8'h40, 8'h1E);
    check("R5 func7", {7'b0, pad_out}, 8'h01);
    @(negedge clk); alt = 7'b1111111;
    wr(8'h40, 8'h10);
    check("R5 func0 uses reg", {7'b0, pad_out}, 8'h00);
    @(negedge clk); alt = '0;
  endtask

  task automatic t_buffer;
    wr(8'h45, 8'h10);
    wr(8'h40, 8'h10);
    check("R6 sink low drives", {7'b0, pad_oe}, 8'h01);
    wr(8'h40, 8'h11);
    check("R6 sink high released", {6'b0, pad_oe, pad_out}, 8'h01);
    wr(8'h45, 8'h20);
    check("R6 source high drives", {7'b0, pad_oe}, 8'h01);
    wr(8'h40, 8'h10);
    check("R6 source low released", {7'b0, pad_oe}, 8'h00);
    wr(8'h45, 8'h30);
    check("R6 code3 push-pull", {7'b0, pad_oe}, 8'h01);
    rchk("R6 buffer readback", 8'h45, 8'h30);
    wr(8'h45, 8'h02);
    check("R12 strength medium", {6'b0, dstr}, 8'h02);
    rchk("R12 drive readback", 8'h45, 8'h02);
  endtask

  task automatic t_bias;
    wr(8'h42, 8'h02);
    check("R9 pull-up variant", {4'b0, pu, pd, pu_sel}, 8'h0A);
    wr(8'h42, 8'h04);
    check("R9 pull-down", {6'b0, pu, pd}, 8'h01);
    wr(8'h42, 8'h07);
    check("R9 code7 no pull", {6'b0, pu, pd}, 8'h00);
  endtask

  task automatic t_master;
    wr(8'h42, 8'h00);
    wr(8'h40, 8'h21);
    wr(8'h45, 8'h03);
    wr(8'h46, 8'h00);
    check("R7 off hiz", {3'b0, pad_oe, in_en, pu, dstr}, 8'h00);
    rchk("R7 enable readback", 8'h46, 8'h00);
    wr(8'h46, 8'h80);
    check("R7 on restored", {3'b0, pad_oe, in_en, pu, dstr}, 8'h1F);
  endtask

  task automatic t_rail;
    logic [7:0] d, dn;
    wr(8'h41, 8'h07);
    rchk("R8 rail 7 on 8-rail", 8'h41, 8'h07);
    check("R8 rail_sel", {5'b0, rail}, 8'h07);
    wr(8'h41, 8'h06);
    rd(8'h41, d, dn);
    check("R8 clamp on 4-rail", dn, 8'h03);
    check("R8 clamp rail_sel", {5'b0, nb_rail}, 8'h03);
    wr(8'h41, 8'h02);
    rd(8'h41, d, dn);
    check("R8 in-range 4-rail", dn, 8'h02);
  endtask

  task automatic t_nobuf;
    logic [7:0] d, dn;
    wr(8'h45, 8'h13);
    rd(8'h45, d, dn);
    check("R10 buffer field zero", dn, 8'h03);
    check("R10 buffered keeps field", d, 8'h13);
    wr(8'h40, 8'h11);
    check("R10 push-pull high", {7'b0, nb_oe}, 8'h01);
    check("R10 buffered released", {7'b0, pad_oe}, 8'h00);
    wr(8'h45, 8'h00);
  endtask

  task automatic t_status;
    wr(8'h40, 8'h00);
    @(negedge clk); pad_in = 1'b1;
    rchk("R11 input high", 8'h10, 8'h01);
    @(negedge clk); pad_in = 1'b0;
    rchk("R11 input low", 8'h10, 8'h00);
    wr(8'h40, 8'h11);
    @(negedge clk); pad_in = 1'b1;
    rchk("R11 output-only masked", 8'h10, 8'h00);
    wr(8'h40, 8'h20);
    rchk("R11 bidir reads pad", 8'h10, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ident;
    t_dir;
    t_func;
    t_buffer;
    t_bias;
    t_master;
    t_rail;
    t_nobuf;
    t_status;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule